// File: doc/BRIEF.md
# Banked Uop Reorder and Align

This block sits after a banked decoded-uop cache. Each cycle every bank presents a fixed group of uop slots, each slot with its own valid bit. Up to two blocks of uops are requested in the same cycle, and each request gives two things: a bank mask naming the banks that hold the block, and an entry offset. A block is stored reversed. Its last uop sits in the first valid slot of its lowest-numbered bank, and earlier uops follow in rising slot order and then rising bank order. The entry offset is the number of valid uops to deliver, counted backward from the block's end.

The block works in two combinational stages. The first stage gathers each request's banks into a block-ordered slot vector. The second stage removes empty slots, drops the uops that lie before the entry point, and reverses what remains into program order. The two results are then packed back to back and registered once. When both requests name a common bank, only the first block is delivered and a deferred flag asks the requester to reissue the second.

Top module: `uop_realign`

## Requirements
- R1: While rst_ni is low, and after it is released until the first request, cnt_o is 0, deferred_o is 0 and every uop slot of uops_o is 0.
- R2: For a block, the stored order is its masked banks in ascending bank index, and within a bank slots 0 to 3 in ascending order. The first valid stored uop is the last uop of the block in program order. Output slot 0 carries the earliest delivered uop.
- R3: With entry offset k and n valid stored uops, the block delivers exactly the first min(k, n) valid stored uops and drops the rest. An offset of 0 delivers nothing.
- R4: Bank slots whose valid bit in bank_vld_i is 0 never appear in the output and leave no gap. Slot s of bank b is bit b*4+s of bank_vld_i and field b*4+s (8 bits each, lowest first) of bank_uops_i.
- R5: When both requests are delivered, the first block's uops occupy output slots 0 up to its count minus 1. The second block's uops follow directly after them.
- R6: When both requests are valid and their masks share a bank, the second block contributes nothing and deferred_o is 1 on the following cycle. Otherwise deferred_o is 0.
- R7: cnt_o equals the number of delivered uops. Every output slot at or above cnt_o is 0.
- R8: Outputs change only at a rising clock edge and reflect the inputs present at that edge (one register of latency).
- R9: A request whose valid bit is 0 contributes nothing. A valid second request with an invalid first request is delivered starting at slot 0.
- R10: cnt_o never exceeds 16. Two disjoint requests covering all four full banks with offsets of 16 deliver all 16 uops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bank_uops_i | input | 128 | Uop slots of all banks, slot b*4+s at bits [(b*4+s)*8 +: 8] |
| bank_vld_i | input | 16 | Per-slot valid bits, bit b*4+s |
| req_a_vld_i | input | 1 | First request valid |
| req_a_mask_i | input | 4 | First request bank mask |
| req_a_ofs_i | input | 5 | First request entry offset (uops from end) |
| req_b_vld_i | input | 1 | Second request valid |
| req_b_mask_i | input | 4 | Second request bank mask |
| req_b_ofs_i | input | 5 | Second request entry offset (uops from end) |
| uops_o | output | 128 | Delivered uops in program order, slot o at [o*8 +: 8] |
| cnt_o | output | 5 | Number of delivered uops |
| deferred_o | output | 1 | Second request was not delivered because of a bank conflict |

## Verification
Every cycle the assertions check the bound on the count, that slots above the count are zero, and that the deferred flag matches a bank conflict one cycle earlier. They also check that idle cycles deliver nothing and that a lone first request never delivers more uops than its offset. Only the bench's sweeps can show what the assertions cannot: that the right uops arrive in the right order. Those sweeps cover every pair of bank masks with varied slot-valid patterns and offsets. They check the reversal into program order, the entry-point cut, the squeezing of empty slots and the placement of the second block after the first, all against an arithmetic model.

// File: rtl/ual_pkg.sv
package ual_pkg;
  localparam int NB_DEF  = 4;
  localparam int UPB_DEF = 4;
  localparam int UW_DEF  = 8;
endpackage

// File: rtl/ual_bank_reorder.sv
module ual_bank_reorder #(
  parameter int NB  = 4,
  parameter int UPB = 4,
  parameter int UW  = 8,
  localparam int SLOTS = NB * UPB
) (
  input  logic [NB-1:0]       mask_i,
  input  logic [SLOTS*UW-1:0] bank_uops_i,
  input  logic [SLOTS-1:0]    bank_vld_i,
  output logic [SLOTS*UW-1:0] slot_uops_o,
  output logic [SLOTS-1:0]    slot_vld_o
);
  // rank of each bank among the masked banks
  int unsigned rank [NB];

  for (genvar b = 0; b < NB; b++) begin : g_rank
    always_comb begin
      rank[b] = 0;
      for (int j = 0; j < b; j++) rank[b] += {31'd0, mask_i[j]};
    end
  end

  always_comb begin
    slot_uops_o = '0;
    slot_vld_o  = '0;
    for (int b = 0; b < NB; b++) begin
      if (mask_i[b]) begin
        for (int s = 0; s < UPB; s++) begin
          slot_uops_o[(rank[b]*UPB+s)*UW +: UW] = bank_uops_i[(b*UPB+s)*UW +: UW];
          slot_vld_o[rank[b]*UPB+s]             = bank_vld_i[b*UPB+s];
        end
      end
    end
  end
endmodule

// File: rtl/ual_block_align.sv
module ual_block_align #(
  parameter int SLOTS = 16,
  parameter int UW    = 8,
  localparam int CW   = $clog2(SLOTS + 1)
) (
  input  logic                en_i,
  input  logic [CW-1:0]       ofs_i,
  input  logic [SLOTS*UW-1:0] slot_uops_i,
  input  logic [SLOTS-1:0]    slot_vld_i,
  output logic [SLOTS*UW-1:0] uops_o,
  output logic [CW-1:0]       cnt_o
);
  int n_vld;
  int keep;
  int idx;

  always_comb begin
    n_vld = 0;
    for (int i = 0; i < SLOTS; i++) n_vld += int'(slot_vld_i[i]);
    if (!en_i)                  keep = 0;
    else if (int'(ofs_i) < n_vld) keep = int'(ofs_i);
    else                        keep = n_vld;
  end

  // compact valid slots, cut at entry point, reverse to program order
  always_comb begin
    uops_o = '0;
    idx    = 0;
    for (int i = 0; i < SLOTS; i++) begin
      if (slot_vld_i[i]) begin
        if (idx < keep) uops_o[(keep-1-idx)*UW +: UW] = slot_uops_i[i*UW +: UW];
        idx++;
      end
    end
    cnt_o = CW'(keep);
  end
endmodule

// File: rtl/ual_merge.sv
module ual_merge #(
  parameter int SLOTS = 16,
  parameter int UW    = 8,
  localparam int CW   = $clog2(SLOTS + 1)
) (
  input  logic [SLOTS*UW-1:0] a_uops_i,
  input  logic [CW-1:0]       a_cnt_i,
  input  logic [SLOTS*UW-1:0] b_uops_i,
  input  logic [CW-1:0]       b_cnt_i,
  output logic [SLOTS*UW-1:0] uops_o,
  output logic [CW-1:0]       cnt_o
);
  int na;
  int nb;

  always_comb begin
    na     = int'(a_cnt_i);
    nb     = int'(b_cnt_i);
    uops_o = '0;
    for (int o = 0; o < SLOTS; o++) begin
      if (o < na)
        uops_o[o*UW +: UW] = a_uops_i[o*UW +: UW];
      else if (o - na < nb)
        uops_o[o*UW +: UW] = b_uops_i[(o-na)*UW +: UW];
    end
    cnt_o = CW'(na + nb);
  end
endmodule

// File: rtl/uop_realign.sv
module uop_realign #(
  parameter int NB  = ual_pkg::NB_DEF,
  parameter int UPB = ual_pkg::UPB_DEF,
  parameter int UW  = ual_pkg::UW_DEF,
  localparam int SLOTS = NB * UPB,
  localparam int CW    = $clog2(SLOTS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SLOTS*UW-1:0] bank_uops_i,
  input  logic [SLOTS-1:0]    bank_vld_i,
  input  logic                req_a_vld_i,
  input  logic [NB-1:0]       req_a_mask_i,
  input  logic [CW-1:0]       req_a_ofs_i,
  input  logic                req_b_vld_i,
  input  logic [NB-1:0]       req_b_mask_i,
  input  logic [CW-1:0]       req_b_ofs_i,
  output logic [SLOTS*UW-1:0] uops_o,
  output logic [CW-1:0]       cnt_o,
  output logic                deferred_o
);
  logic conflict;
  logic b_en;
  assign conflict = req_a_vld_i & req_b_vld_i & |(req_a_mask_i & req_b_mask_i);
  assign b_en     = req_b_vld_i & ~conflict;

  logic [NB-1:0]       mask   [2];
  logic [CW-1:0]       ofs    [2];
  logic                en     [2];
  logic [SLOTS*UW-1:0] ro_u   [2];
  logic [SLOTS-1:0]    ro_v   [2];
  logic [SLOTS*UW-1:0] al_u   [2];
  logic [CW-1:0]       al_c   [2];

  assign mask[0] = req_a_mask_i;
  assign mask[1] = req_b_mask_i;
  assign ofs[0]  = req_a_ofs_i;
  assign ofs[1]  = req_b_ofs_i;
  assign en[0]   = req_a_vld_i;
  assign en[1]   = b_en;

  for (genvar r = 0; r < 2; r++) begin : g_req
    ual_bank_reorder #(.NB(NB), .UPB(UPB), .UW(UW)) u_reorder (
      .mask_i      (mask[r]),
      .bank_uops_i (bank_uops_i),
      .bank_vld_i  (bank_vld_i),
      .slot_uops_o (ro_u[r]),
      .slot_vld_o  (ro_v[r])
    );
    ual_block_align #(.SLOTS(SLOTS), .UW(UW)) u_align (
      .en_i        (en[r]),
      .ofs_i       (ofs[r]),
      .slot_uops_i (ro_u[r]),
      .slot_vld_i  (ro_v[r]),
      .uops_o      (al_u[r]),
      .cnt_o       (al_c[r])
    );
  end

  logic [SLOTS*UW-1:0] mg_u;
  logic [CW-1:0]       mg_c;

  ual_merge #(.SLOTS(SLOTS), .UW(UW)) u_merge (
    .a_uops_i (al_u[0]),
    .a_cnt_i  (al_c[0]),
    .b_uops_i (al_u[1]),
    .b_cnt_i  (al_c[1]),
    .uops_o   (mg_u),
    .cnt_o    (mg_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uops_o     <= '0;
      cnt_o      <= '0;
      deferred_o <= 1'b0;
    end else begin
      uops_o     <= mg_u;
      cnt_o      <= mg_c;
      deferred_o <= conflict;
    end
  end
endmodule

// File: rtl/uop_realign_chk.sv
module uop_realign_chk #(
  parameter int NB  = 4,
  parameter int UPB = 4,
  parameter int UW  = 8,
  localparam int SLOTS = NB * UPB,
  localparam int CW    = $clog2(SLOTS + 1)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_a_vld_i,
  input logic [NB-1:0]       req_a_mask_i,
  input logic [CW-1:0]       req_a_ofs_i,
  input logic                req_b_vld_i,
  input logic [NB-1:0]       req_b_mask_i,
  input logic [SLOTS*UW-1:0] uops_o,
  input logic [CW-1:0]       cnt_o,
  input logic                deferred_o
);
  logic clash;
  assign clash = req_a_vld_i && req_b_vld_i && ((req_a_mask_i & req_b_mask_i) != '0);

  p_cnt_max_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_o) <= SLOTS);

  p_defer_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clash |=> deferred_o);

  p_defer_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clash |=> !deferred_o);

  p_idle_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_a_vld_i && !req_b_vld_i) |=> (cnt_o == '0));

  p_ofs_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_a_vld_i && !req_b_vld_i) |=> (cnt_o <= $past(req_a_ofs_i)));

  for (genvar o = 0; o < SLOTS; o++) begin : g_pad
    p_pad_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(cnt_o) <= o) |-> (uops_o[o*UW +: UW] == '0));
  end
endmodule

bind uop_realign uop_realign_chk #(.NB(NB), .UPB(UPB), .UW(UW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_a_vld_i  (req_a_vld_i),
  .req_a_mask_i (req_a_mask_i),
  .req_a_ofs_i  (req_a_ofs_i),
  .req_b_vld_i  (req_b_vld_i),
  .req_b_mask_i (req_b_mask_i),
  .uops_o       (uops_o),
  .cnt_o        (cnt_o),
  .deferred_o   (deferred_o)
);

// File: tb/uop_realign_test.sv
module uop_realign_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4, UPB = 4, UW = 8;
  localparam int SLOTS = NB * UPB;
  localparam int CW = $clog2(SLOTS + 1);

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic [SLOTS*UW-1:0] bank_uops_i = '0;
  logic [SLOTS-1:0]    bank_vld_i = '0;
  logic                req_a_vld_i = 1'b0, req_b_vld_i = 1'b0;
  logic [NB-1:0]       req_a_mask_i = '0, req_b_mask_i = '0;
  logic [CW-1:0]       req_a_ofs_i = '0, req_b_ofs_i = '0;
  logic [SLOTS*UW-1:0] uops_o;
  logic [CW-1:0]       cnt_o;
  logic                deferred_o;

  int checks = 0;
  int fails = 0;
  logic [SLOTS*UW-1:0] exp_u;
  int exp_c;
  int exp_d;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  uop_realign uut (
    .clk_i, .rst_ni, .bank_uops_i, .bank_vld_i,
    .req_a_vld_i, .req_a_mask_i, .req_a_ofs_i,
    .req_b_vld_i, .req_b_mask_i, .req_b_ofs_i,
    .uops_o, .cnt_o, .deferred_o
  );

  task automatic check_int(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_vec(string tag, logic [SLOTS*UW-1:0] act, logic [SLOTS*UW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s uops actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // append one block to the expected vector
  task automatic add_block(logic [NB-1:0] m, int k);
    logic [UW-1:0] lst [SLOTS];
    int n = 0;
    int keep;
    for (int b = 0; b < NB; b++)
      if (m[b])
        for (int s = 0; s < UPB; s++)
          if (bank_vld_i[b*UPB+s]) begin
            lst[n] = bank_uops_i[(b*UPB+s)*UW +: UW];
            n++;
          end
    keep = (k < n) ? k : n;
    for (int i = keep - 1; i >= 0; i--) begin
      exp_u[exp_c*UW +: UW] = lst[i];
      exp_c++;
    end
  endtask

  task automatic fill_banks(int seed, logic [SLOTS-1:0] vld);
    for (int i = 0; i < SLOTS; i++)
      bank_uops_i[i*UW +: UW] = UW'(16 * (seed % 15 + 1) + i);
    bank_vld_i = vld;
  endtask

  // drive at negedge, check one clock later
  task automatic run(string tag, logic av, logic [NB-1:0] am, int ao,
                     logic bv, logic [NB-1:0] bm, int bo);
    @(negedge clk_i);
    req_a_vld_i = av; req_a_mask_i = am; req_a_ofs_i = CW'(ao);
    req_b_vld_i = bv; req_b_mask_i = bm; req_b_ofs_i = CW'(bo);
    exp_u = '0; exp_c = 0;
    exp_d = (av && bv && ((am & bm) != '0)) ? 1 : 0;
    if (av) add_block(am, ao);
    if (bv && exp_d == 0) add_block(bm, bo);
    @(negedge clk_i);
    check_int(tag, "cnt", int'(cnt_o), exp_c);
    check_int(tag, "deferred", int'(deferred_o), exp_d);
    check_vec(tag, uops_o, exp_u);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(negedge clk_i);
    check_int("R1", "cnt in reset", int'(cnt_o), 0);
    check_int("R1", "deferred in reset", int'(deferred_o), 0);
    check_vec("R1", uops_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_int("R1", "cnt after reset", int'(cnt_o), 0);

    // R2 single block across banks 1 and 3, all valid, full entry
    fill_banks(3, '1);
    run("R2", 1, 4'b1010, 16, 0, 4'b0000, 0);
    // R3 entry offsets: zero, partial, beyond size
    run("R3", 1, 4'b0110, 0, 0, 4'b0000, 0);
    run("R3", 1, 4'b0110, 5, 0, 4'b0000, 0);
    run("R3", 1, 4'b0001, 9, 0, 4'b0000, 0);
    // R4 sparse and fully empty banks
    fill_banks(5, 16'b0101_0000_1001_0110);
    run("R4", 1, 4'b1011, 16, 0, 4'b0000, 0);
    fill_banks(6, '0);
    run("R4", 1, 4'b1111, 16, 0, 4'b0000, 0);
    // R5 two disjoint blocks back to back
    fill_banks(7, 16'b1110_0111_1011_1101);
    run("R5", 1, 4'b0100, 3, 1, 4'b1001, 16);
    // R6 conflicting requests
    run("R6", 1, 4'b0110, 16, 1, 4'b0011, 16);
    // R9 only second valid, then nothing valid
    run("R9", 0, 4'b1111, 16, 1, 4'b0010, 4);
    run("R9", 0, 4'b1111, 16, 0, 4'b1111, 16);
    // R10 full delivery
    fill_banks(8, '1);
    run("R10", 1, 4'b0011, 16, 1, 4'b1100, 16);

    // R8 output holds until the rising edge
    @(negedge clk_i);
    req_a_vld_i = 1'b0; req_b_vld_i = 1'b0;
    #1;
    check_int("R8", "cnt before edge", int'(cnt_o), 16);
    @(negedge clk_i);
    check_int("R8", "cnt after edge", int'(cnt_o), 0);

    // sweep all mask pairs with pseudo-random valid patterns and offsets
    for (int am = 0; am < 16; am++) begin
      for (int bm = 0; bm < 16; bm++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        fill_banks(am * 16 + bm, lfsr);
        run(((am & bm) != 0) ? "R6/R7" : "R2/R3/R4/R5/R7",
            1, NB'(am), (am * 7 + bm * 3) % 18,
            (bm % 3) != 0, NB'(bm), (am + bm * 5) % 18);
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule